// File: doc/BRIEF.md
# Data-Ready Bus Interrupter

This block raises a bus interrupt request for as long as a wired-OR data-ready line from a set of acquisition buffers stays high. Software programs an interrupt level and an 8-bit status/ID vector through two write-only registers. While data-ready is seen high and the level is non-zero, exactly one request line is driven: the line that belongs to the programmed level. Level zero turns interrupt generation off, and reset leaves the level at zero.

When the bus master runs an acknowledge cycle for the same level while the request is active, the block answers with its vector and a one-cycle done strobe. The acknowledge does not withdraw the request. The request is released only when data-ready falls, which means every buffer has been drained. The data-ready input is asynchronous and passes through a two-flop synchroniser before the block uses it.

Top module: `rdy_irq_top`

## Requirements
- R1: After synchronous reset, `irq_req`, `iack_done` and `iack_data` are all zero and the level is zero. A data-ready input that is high does not raise any request until a non-zero level is written.
- R2: When `data_rdy_in` rises between two clock edges, `irq_req` is still zero after the second rising edge that follows and becomes active after the third. This is two synchroniser stages plus the request register.
- R3: With level 0 programmed, `irq_req` stays all zero and no acknowledge produces `iack_done`.
- R4: With level L in 1..7 and data-ready high, only bit L-1 of `irq_req` is set. `irq_req` is never more than one-hot.
- R5: After `data_rdy_in` falls, `irq_req` stays active after the second following edge and is all zero after the third.
- R6: An acknowledge cycle, matching or not, leaves `irq_req` unchanged.
- R7: An `iack_stb` cycle whose `iack_lvl` equals the non-zero programmed level while the request is active makes `iack_done` high, with `iack_data` equal to the stored vector, in the cycle after the strobe edge. Both outputs return to zero in the following cycle once the strobe is removed.
- R8: An acknowledge with a different level, or with no request active, gives `iack_done` = 0 and `iack_data` = 0.
- R9: A vector write is returned by the next matching acknowledge. A level write while data-ready is high moves the request to the new line two edges after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_we | input | 1 | Write strobe for the level register |
| lvl_wdata | input | LVL_W | Interrupt level to store (0 disables) |
| vec_we | input | 1 | Write strobe for the status/ID register |
| vec_wdata | input | VEC_W | Status/ID vector to store |
| data_rdy_in | input | 1 | Asynchronous wired-OR data-ready |
| iack_stb | input | 1 | Acknowledge cycle strobe |
| iack_lvl | input | LVL_W | Level being acknowledged |
| irq_req | output | 2**LVL_W-1 | Request lines; bit k is level k+1 |
| iack_data | output | VEC_W | Vector returned on acknowledge |
| iack_done | output | 1 | One-cycle acknowledge completion strobe |

## Verification
The bench uses the default 3-bit level and 8-bit vector. With these widths it can sweep every programmed level against every acknowledged level, 64 pairings in all. Each pairing gets its own vector, computed from the level, so a wrong vector or a reply on the wrong level shows up directly. The edge-exact latency of the request on the rise and on the fall of data-ready is checked around a level change. The bench also checks that acknowledges never release the request.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Pad the request vector with a zero at index 0 so that level code n picks bit n.
  function automatic logic lvl_hit(input logic [15:0] padded, input int unsigned lvl);
    return padded[lvl];
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_we,
  input  logic [LVL_W-1:0] lvl_wdata,
  input  logic             vec_we,
  input  logic [VEC_W-1:0] vec_wdata,
  output logic [LVL_W-1:0] lvl_q,
  output logic [VEC_W-1:0] vec_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      vec_q <= '0;
    end else begin
      if (lvl_we) lvl_q <= lvl_wdata;
      if (vec_we) vec_q <= vec_wdata;
    end
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int LVL_W = 3,
  localparam int NLVL = (1 << LVL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rdy_s,
  input  logic [LVL_W-1:0] lvl_q,
  output logic [NLVL-1:0]  irq_req
);
  for (genvar g = 0; g < NLVL; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) irq_req[g] <= 1'b0;
      else     irq_req[g] <= rdy_s && (lvl_q == LVL_W'(g + 1));
    end
  end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8,
  localparam int NLVL = (1 << LVL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iack_stb,
  input  logic [LVL_W-1:0] iack_lvl,
  input  logic [LVL_W-1:0] lvl_q,
  input  logic [VEC_W-1:0] vec_q,
  input  logic [NLVL-1:0]  irq_req,
  output logic [VEC_W-1:0] iack_data,
  output logic             iack_done
);
  logic [NLVL:0] padded;
  logic          hit;

  assign padded = {irq_req, 1'b0};

  always_comb begin
    hit = iack_stb && (iack_lvl == lvl_q) && padded[lvl_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iack_done <= 1'b0;
      iack_data <= '0;
    end else begin
      iack_done <= hit;
      iack_data <= hit ? vec_q : '0;
    end
  end
endmodule

// File: rtl/rdy_irq_top.sv
module rdy_irq_top #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NLVL = (1 << LVL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_we,
  input  logic [LVL_W-1:0] lvl_wdata,
  input  logic             vec_we,
  input  logic [VEC_W-1:0] vec_wdata,
  input  logic             data_rdy_in,
  input  logic             iack_stb,
  input  logic [LVL_W-1:0] iack_lvl,
  output logic [NLVL-1:0]  irq_req,
  output logic [VEC_W-1:0] iack_data,
  output logic             iack_done
);
  logic             rdy_s;
  logic [LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0] vec_q;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(data_rdy_in), .d_sync(rdy_s)
  );

  irq_regs #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst(rst),
    .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
    .vec_we(vec_we), .vec_wdata(vec_wdata),
    .lvl_q(lvl_q), .vec_q(vec_q)
  );

  irq_req_gen #(.LVL_W(LVL_W)) u_req (
    .clk(clk), .rst(rst), .rdy_s(rdy_s), .lvl_q(lvl_q), .irq_req(irq_req)
  );

  irq_ack_unit #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_ack (
    .clk(clk), .rst(rst),
    .iack_stb(iack_stb), .iack_lvl(iack_lvl),
    .lvl_q(lvl_q), .vec_q(vec_q), .irq_req(irq_req),
    .iack_data(iack_data), .iack_done(iack_done)
  );
endmodule

// File: rtl/rdy_irq_chk.sv
module rdy_irq_chk #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8,
  localparam int NLVL = (1 << LVL_W) - 1
) (
  input logic             clk,
  input logic             rst,
  input logic             rdy_s,
  input logic [LVL_W-1:0] lvl_q,
  input logic             iack_stb,
  input logic [NLVL-1:0]  irq_req,
  input logic [VEC_W-1:0] iack_data,
  input logic             iack_done
);
  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_req)); // R4
  AST_ZERO_LVL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (lvl_q == '0) |=> (irq_req == '0) && !iack_done); // R3
  AST_DROP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    !rdy_s |=> (irq_req == '0)); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (rdy_s && lvl_q != '0) |=> (irq_req != '0)); // R6
  AST_DONE_NEEDS_STB: assert property (@(posedge clk) disable iff (rst)
    iack_done |-> $past(iack_stb)); // R7
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !iack_done |-> (iack_data == '0)); // R8
endmodule

bind rdy_irq_top rdy_irq_chk #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .rdy_s(rdy_s), .lvl_q(lvl_q), .iack_stb(iack_stb),
  .irq_req(irq_req), .iack_data(iack_data), .iack_done(iack_done)
);

// File: tb/tb_rdy_irq_top.sv
module tb_rdy_irq_top;
  localparam int LVL_W = 3;
  localparam int VEC_W = 8;
  localparam int NLVL = (1 << LVL_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             lvl_we = 1'b0;
  logic [LVL_W-1:0] lvl_wdata = '0;
  logic             vec_we = 1'b0;
  logic [VEC_W-1:0] vec_wdata = '0;
  logic             data_rdy_in = 1'b0;
  logic             iack_stb = 1'b0;
  logic [LVL_W-1:0] iack_lvl = '0;
  logic [NLVL-1:0]  irq_req;
  logic [VEC_W-1:0] iack_data;
  logic             iack_done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rdy_irq_top #(.LVL_W(LVL_W), .VEC_W(VEC_W)) dut (
    .clk(clk), .rst(rst), .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
    .vec_we(vec_we), .vec_wdata(vec_wdata), .data_rdy_in(data_rdy_in),
    .iack_stb(iack_stb), .iack_lvl(iack_lvl),
    .irq_req(irq_req), .iack_data(iack_data), .iack_done(iack_done)
  );

  function automatic logic [NLVL-1:0] exp_req(input int l);
    return (l == 0) ? '0 : NLVL'(1) << (l - 1);
  endfunction

  function automatic logic [VEC_W-1:0] vec_for(input int l);
    return VEC_W'(8'h3C ^ (l * 8'h25));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic write_lvl_vec(input int l, input logic [VEC_W-1:0] v);
    @(negedge clk);
    lvl_we = 1'b1; lvl_wdata = LVL_W'(l);
    vec_we = 1'b1; vec_wdata = v;
    @(negedge clk);
    lvl_we = 1'b0; vec_we = 1'b0;
  endtask

  task automatic do_ack(input int a, input bit exp_done, input logic [VEC_W-1:0] exp_data,
                        input logic [NLVL-1:0] req_before);
    @(negedge clk);
    iack_stb = 1'b1; iack_lvl = LVL_W'(a);
    tick_n(1);
    if (exp_done) begin
      check(iack_done == 1'b1, "R7 done", int'(iack_done), 1);
      check(iack_data == exp_data, "R7 data", int'(iack_data), int'(exp_data));
    end else begin
      check(iack_done == 1'b0, "R8 done", int'(iack_done), 0);
      check(iack_data == '0, "R8 data", int'(iack_data), 0);
    end
    @(negedge clk);
    iack_stb = 1'b0;
    tick_n(1);
    check(iack_done == 1'b0, "R7 strobe single", int'(iack_done), 0);
    check(irq_req == req_before, "R6 req kept", int'(irq_req), int'(req_before));
  endtask

  initial begin
    #(20_000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick_n(3);
    check(irq_req == '0 && !iack_done && iack_data == '0, "R1 reset outputs",
          int'(irq_req), 0);
    @(negedge clk);
    rst = 1'b0;
    data_rdy_in = 1'b1;
    tick_n(5);
    check(irq_req == '0, "R1 level zero after reset", int'(irq_req), 0);

    // Sweep programmed level against every acknowledged level.
    for (int l = 0; l <= NLVL; l++) begin
      write_lvl_vec(l, vec_for(l));
      tick_n(1);
      check(irq_req == exp_req(l), (l == 0) ? "R3 level zero" : "R4 one-hot line",
            int'(irq_req), int'(exp_req(l)));
      for (int a = 0; a <= NLVL; a++) begin
        do_ack(a, (a == l) && (l != 0), vec_for(l), exp_req(l));
      end
    end

    // Release timing at level 5.
    write_lvl_vec(5, 8'h5A);
    tick_n(1);
    @(negedge clk);
    data_rdy_in = 1'b0;
    tick_n(2);
    check(irq_req == exp_req(5), "R5 still held after two edges", int'(irq_req),
          int'(exp_req(5)));
    tick_n(1);
    check(irq_req == '0, "R5 released after three edges", int'(irq_req), 0);
    do_ack(5, 1'b0, '0, '0);

    // Rise timing.
    @(negedge clk);
    data_rdy_in = 1'b1;
    tick_n(2);
    check(irq_req == '0, "R2 not yet after two edges", int'(irq_req), 0);
    tick_n(1);
    check(irq_req == exp_req(5), "R2 active after three edges", int'(irq_req),
          int'(exp_req(5)));

    // Vector rewrite and level move while requesting.
    write_lvl_vec(5, 8'hC3);
    do_ack(5, 1'b1, 8'hC3, exp_req(5));
    @(negedge clk);
    lvl_we = 1'b1; lvl_wdata = LVL_W'(2);
    @(negedge clk);
    lvl_we = 1'b0;
    #1;
    check(irq_req == exp_req(5), "R9 old line one edge after write", int'(irq_req),
          int'(exp_req(5)));
    tick_n(1);
    check(irq_req == exp_req(2), "R9 moved line", int'(irq_req), int'(exp_req(2)));
    do_ack(2, 1'b1, 8'hC3, exp_req(2));
    do_ack(5, 1'b0, '0, exp_req(2));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule